// File: doc/BRIEF.md
# Quad-Modulus Fractional-N Feedback Divider Controller

This block sets the feedback division of an RF synthesizer whose front end is a four-modulus prescaler. It runs on the prescaler output clock, so each of its clock cycles is one prescaler output cycle. Each cycle it drives two modulus-select lines: one adds 1 and the other adds 4 to the prescaler base P. Once per division period it emits a one-cycle feedback pulse for the phase detector.

The integer ratio N is split into three counts. C is the number of prescaler cycles in the period. B is the number of those cycles that use the +4 modulus. A is the number that use the +1 modulus. A fractional accumulator adds a programmable numerator once per period, modulo a programmable denominator. Each overflow adds one more +1 cycle, which swallows one extra VCO cycle in that period, so the long-run ratio is N + num/den. A band input picks base 16 (moduli 16/17/20/21) or base 8 (moduli 8/9/12/13).

The integer word, fraction and band are sampled only at period boundaries. A synchronous power-down clears the counters and the accumulator. When power-down is released, a new period starts on the next clock edge, so the restart stays aligned with the reference divider.

Top module: `qmod_fracn_div`

## Requirements
- R1: During reset and during every cycle that follows a clock edge sampled with `pwr_dn` high, `fb_pulse` = 0, `mod_sel` = 2'b00 and `cfg_err` = 0.
- R2: `mod_sel[1]` adds 4 and `mod_sel[0]` adds 1 to the prescaler base. In each period, `mod_sel[1]` is high in the first B cycles and `mod_sel[0]` is high in the first A' cycles, where A' = A plus 1 on an overflow period. Neither bit rises again before the next feedback pulse.
- R3: With `band_hi` = 1, P = 16, C = N div 16, B = (N mod 16) div 4 and A = N mod 4. With `band_hi` = 0, P = 8 and C = N div 8, with B and A taken from N mod 8 in the same way.
- R4: With numerator 0, every legal period lasts exactly N VCO cycles, where a period's VCO count is the sum of P + 4*`mod_sel[1]` + `mod_sel[0]` over the cycles from one feedback pulse up to the next.
- R5: The accumulator is cleared by reset and power-down. Each period it adds `frac_num`, and a period in which the sum reaches the effective denominator lasts N+1 VCO cycles. Over one full denominator of periods the total is den*N + num, provided num < den.
- R6: Denominator codes 0 to 8 act as 16, and codes 9 to 15 act as their own value.
- R7: `n_word`, `band_hi`, `frac_num` and `frac_den` are sampled only on the clock edge that starts a period. A change during a period does not alter that period's length.
- R8: `cfg_err` is set for a whole period when that period's C is below max(A,B)+2 or does not fit 11 bits. Feedback pulses continue while it is set.
- R9: After `pwr_dn` or reset falls, the first feedback pulse comes in the cycle after the first clock edge.
- R10: `fb_pulse` is high for exactly one cycle per period when `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low reset |
| pwr_dn | input | 1 | Synchronous power-down; clears counters and accumulator |
| band_hi | input | 1 | 1 selects base 16, 0 selects base 8 |
| n_word | input | 15 | Integer division ratio N |
| frac_num | input | 4 | Fraction numerator |
| frac_den | input | 4 | Fraction denominator code |
| mod_sel | output | 2 | Modulus select: bit 1 adds 4, bit 0 adds 1 |
| fb_pulse | output | 1 | One-cycle feedback pulse at the start of each period |
| cfg_err | output | 1 | Integer word violates the counter constraint or range |

## Verification
The bench uses the default 15-bit integer word and 4-bit fraction, and runs both bands. That brings the end values 40, 16383, 80 and 32767 within reach, and also the 11-bit overflow of C in the low band. The 4-bit fraction lets every denominator code from 0 to 15 be run for a full cycle of 16 periods in little time. Small N values near the C >= max(A,B)+2 boundary check the error flag on both sides of the limit.

// File: rtl/qmfn_pkg.sv
package qmfn_pkg;
    // shift amounts for the two prescaler bases (16 and 8)
    localparam int HI_SH = 4;
    localparam int LO_SH = 3;
    // width of the +4 and +1 counts
    localparam int AB_W  = 2;
endpackage

// File: rtl/qmfn_split.sv
module qmfn_split #(
    parameter int N_W = 15,
    parameter int C_W = 11
) (
    input  logic [N_W-1:0]              n_word,
    input  logic                        band_hi,
    output logic [C_W-1:0]              c_val,
    output logic [qmfn_pkg::AB_W-1:0]   b_val,
    output logic [qmfn_pkg::AB_W-1:0]   a_val,
    output logic                        bad
);
    import qmfn_pkg::*;
    localparam int CF_W  = N_W - LO_SH;
    localparam int C_MAX = (1 << C_W) - 1;

    logic [CF_W-1:0]   c_full;
    logic [HI_SH-1:0]  rem;
    logic [AB_W-1:0]   mx;

    always_comb begin
        c_full = band_hi ? CF_W'(n_word >> HI_SH) : CF_W'(n_word >> LO_SH);
        rem    = band_hi ? n_word[HI_SH-1:0] : {1'b0, n_word[LO_SH-1:0]};
        b_val  = rem[HI_SH-1:AB_W];
        a_val  = rem[AB_W-1:0];
        mx     = (a_val > b_val) ? a_val : b_val;
        c_val  = c_full[C_W-1:0];
        bad    = (c_full > CF_W'(C_MAX)) || (c_full < (CF_W'(mx) + CF_W'(2)));
    end
endmodule

// File: rtl/qmfn_frac_acc.sv
module qmfn_frac_acc #(
    parameter int F_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           load,
    input  logic [F_W-1:0] num,
    input  logic [F_W-1:0] den_code,
    output logic           ovf
);
    localparam int D_W     = F_W + 1;
    localparam int LOW_LIM = (1 << (F_W - 1)) + 1;

    logic [F_W-1:0] acc_d, acc_q;
    logic [D_W-1:0] sum, den, rsd;

    always_comb begin
        den   = (int'(den_code) < LOW_LIM) ? D_W'(1 << F_W) : {1'b0, den_code};
        sum   = {1'b0, acc_q} + {1'b0, num};
        ovf   = (sum >= den);
        rsd   = ovf ? (sum - den) : sum;
        acc_d = acc_q;
        if (clr)
            acc_d = '0;
        else if (load)
            acc_d = rsd[F_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R5: a legal step leaves a residue below the denominator in use
    a_r5_acc_residue: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr && ({1'b0, num} < den) && ({1'b0, acc_q} < den))
        |=> ({1'b0, acc_q} < $past(den)));
endmodule

// File: rtl/qmod_fracn_div.sv
module qmod_fracn_div #(
    parameter int N_W = 15,
    parameter int F_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_dn,
    input  logic           band_hi,
    input  logic [N_W-1:0] n_word,
    input  logic [F_W-1:0] frac_num,
    input  logic [F_W-1:0] frac_den,
    output logic [1:0]     mod_sel,
    output logic           fb_pulse,
    output logic           cfg_err
);
    import qmfn_pkg::*;
    localparam int C_W = N_W - HI_SH;
    localparam int A_W = AB_W + 1;

    typedef struct packed {
        logic [C_W-1:0]  c;
        logic [AB_W-1:0] b;
        logic [A_W-1:0]  a;
        logic            fb;
        logic            err;
    } div_st_t;

    div_st_t st_d, st_q;

    logic [C_W-1:0]  c_val;
    logic [AB_W-1:0] b_val, a_val;
    logic            bad, ovf, last, load;

    qmfn_split #(.N_W(N_W), .C_W(C_W)) u_split (
        .n_word (n_word),
        .band_hi(band_hi),
        .c_val  (c_val),
        .b_val  (b_val),
        .a_val  (a_val),
        .bad    (bad)
    );

    qmfn_frac_acc #(.F_W(F_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pwr_dn),
        .load    (load),
        .num     (frac_num),
        .den_code(frac_den),
        .ovf     (ovf)
    );

    always_comb begin
        last = (st_q.c <= C_W'(1));
        load = last && !pwr_dn;
        st_d = st_q;
        if (pwr_dn) begin
            st_d = '0;
        end else if (last) begin
            st_d.c   = c_val;
            st_d.b   = b_val;
            st_d.a   = {1'b0, a_val} + A_W'(ovf);
            st_d.fb  = 1'b1;
            st_d.err = bad;
        end else begin
            st_d.c  = st_q.c - 1'b1;
            st_d.b  = (st_q.b != '0) ? st_q.b - 1'b1 : '0;
            st_d.a  = (st_q.a != '0) ? st_q.a - 1'b1 : '0;
            st_d.fb = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mod_sel  = {|st_q.b, |st_q.a};
    assign fb_pulse = st_q.fb;
    assign cfg_err  = st_q.err;

    // R1: power-down leaves the outputs quiet
    a_r1_pwrdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!fb_pulse && (mod_sel == 2'b00) && !cfg_err));

    // R2: the +4 select never rises inside a period
    a_r2_plus4_once: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_pulse |-> !(mod_sel[1] && !$past(mod_sel[1])));

    // R2: the +1 select never rises inside a period
    a_r2_plus1_once: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_pulse |-> !(mod_sel[0] && !$past(mod_sel[0])));

    // R9: the cycle after the last count always opens a period
    a_r9_next_period: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !pwr_dn) |=> fb_pulse);

    // R10: a legal period gives a single-cycle feedback pulse
    a_r10_fb_single: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && !cfg_err) |=> !fb_pulse);
endmodule

// File: tb/qmod_fracn_div_bench.sv
module qmod_fracn_div_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        band_hi = 1'b1;
    logic [14:0] n_word = 15'd80;
    logic [3:0]  frac_num = 4'd0;
    logic [3:0]  frac_den = 4'd0;
    logic [1:0]  mod_sel;
    logic        fb_pulse;
    logic        cfg_err;

    int vec = 0;
    int bad = 0;

    always #5 clk = ~clk;

    qmod_fracn_div u_qmod_fracn_div (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .band_hi(band_hi),
        .n_word(n_word), .frac_num(frac_num), .frac_den(frac_den),
        .mod_sel(mod_sel), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int den_eff(input int code);
        return (code < 9) ? 16 : code;
    endfunction

    function automatic bit word_bad(input int n, input bit bh);
        int p, c, b, a, m;
        p = bh ? 16 : 8;
        c = n / p; b = (n % p) / 4; a = (n % p) % 4;
        m = (a > b) ? a : b;
        return (c > 2047) || (c < m + 2);
    endfunction

    task automatic wait_fb(output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!fb_pulse && cnt < 5000);
    endtask

    // called at the negedge of a feedback cycle; returns at the next one
    task automatic measure(input int n, input bit bh, input int ovf, input string req,
                           output int len);
        int p, b, a, j;
        bit pat_ok;
        p = bh ? 16 : 8;
        b = (n % p) / 4;
        a = (n % p) % 4 + ovf;
        len = 0; j = 0; pat_ok = 1'b1;
        do begin
            if (mod_sel[1] != (j < b) || mod_sel[0] != (j < a)) pat_ok = 1'b0;
            len += p + (mod_sel[1] ? 4 : 0) + (mod_sel[0] ? 1 : 0);
            j++;
            @(negedge clk);
        end while (!fb_pulse && j < 5000);
        chk(len == n + ovf, req, len, n + ovf);
        chk(pat_ok, "R2 order", pat_ok, 1);
    endtask

    task automatic run_case(input int n, input bit bh, input int num, input int dcode,
                            input int periods, input string req, output int total);
        int acc, de, sum, ovf, len, cnt;
        @(negedge clk);
        pwr_dn = 1'b1; band_hi = bh; n_word = 15'(n);
        frac_num = 4'(num); frac_den = 4'(dcode);
        @(negedge clk);
        pwr_dn = 1'b0;
        wait_fb(cnt);
        chk(cnt == 1, "R9 restart", cnt, 1);
        acc = 0; de = den_eff(dcode); total = 0;
        for (int p = 0; p < periods; p++) begin
            sum = acc + num;
            ovf = (sum >= de) ? 1 : 0;
            acc = ovf ? sum - de : sum;
            measure(n, bh, ovf, req, len);
            total += len;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vec++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int tot, len, cnt, n, bh, dc, nm, de;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!fb_pulse && mod_sel == 2'b00 && !cfg_err, "R1 reset", {fb_pulse, mod_sel, cfg_err}, 0);
        rst_n = 1'b1;
        wait_fb(cnt);
        chk(cnt == 1, "R9 after reset", cnt, 1);

        // R4 / R3 integer end points on both bands
        run_case(80, 1, 0, 0, 3, "R4 R3 n80 hi", tot);
        run_case(32767, 1, 0, 0, 2, "R4 R3 n32767 hi", tot);
        run_case(40, 0, 0, 0, 3, "R4 R3 n40 lo", tot);
        run_case(16383, 0, 0, 0, 2, "R4 R3 n16383 lo", tot);
        run_case(95, 1, 0, 0, 3, "R4 n95 tight C", tot);
        chk(!cfg_err, "R8 n95 legal", cfg_err, 0);

        // R5 / R6 fractional totals over a full denominator
        run_case(100, 1, 6, 0, 16, "R5 num6 den0", tot);
        chk(tot == 16 * 100 + 6, "R5 total den0", tot, 1606);
        run_case(90, 1, 8, 9, 9, "R6 den9", tot);
        chk(tot == 9 * 90 + 8, "R6 total den9", tot, 818);
        run_case(61, 0, 3, 5, 16, "R6 den5 as16", tot);
        chk(tot == 16 * 61 + 3, "R6 total den5", tot, 979);
        run_case(61, 0, 15, 8, 16, "R6 den8 as16", tot);
        chk(tot == 16 * 61 + 15, "R6 total den8", tot, 991);
        run_case(120, 1, 14, 15, 15, "R6 den15", tot);
        chk(tot == 15 * 120 + 14, "R6 total den15", tot, 1814);

        // R7: words changed mid-period take effect next period
        run_case(200, 1, 0, 0, 1, "R7 setup", tot);
        n_word = 15'd150;
        measure(200, 1, 0, "R7 old word kept", len);
        measure(150, 1, 0, "R7 new word next", len);

        // R8: constraint violations flag and keep running
        run_case(80, 1, 0, 0, 1, "R8 setup", tot);
        n_word = 15'd47;
        wait_fb(cnt);
        chk(cfg_err == 1'b1, "R8 C below limit", cfg_err, 1);
        wait_fb(cnt);
        chk(fb_pulse == 1'b1, "R8 still pulsing", fb_pulse, 1);
        band_hi = 1'b0; n_word = 15'd20000;
        wait_fb(cnt); wait_fb(cnt);
        chk(cfg_err == 1'b1, "R8 C too wide", cfg_err, 1);
        band_hi = 1'b1; n_word = 15'd79;
        wait_fb(cnt); wait_fb(cnt);
        chk(cfg_err == 1'b1, "R8 n79", cfg_err, 1);

        // R1: power-down quiet
        @(negedge clk); pwr_dn = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!fb_pulse && mod_sel == 2'b00 && !cfg_err, "R1 pwr_dn", {fb_pulse, mod_sel, cfg_err}, 0);
        end

        // R10 and random mix
        for (int k = 0; k < 25; k++) begin
            bh = $urandom % 2;
            n  = (bh ? 80 : 40) + $urandom % 1500;
            while (word_bad(n, bh[0])) n += bh ? 16 : 8;
            dc = $urandom % 16;
            de = den_eff(dc);
            nm = $urandom % de;
            run_case(n, bh[0], nm, dc, 5, "R4 R5 random", tot);
            chk(!cfg_err, "R10 legal no err", cfg_err, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule